// File: doc/BRIEF.md
# Edge-Selective Deskew Delay Unit

This block holds back the transitions of repeated bus lines by a whole number of system clock cycles. A bus repeater places one instance on each signal class so that a strobe cannot reach the far side before the lines it qualifies. The delay is given in nanoseconds together with the clock period. The block converts it to cycles, rounding up, so it never delays less than asked.

Each instance works in one of two modes. In the symmetric mode the unit is a shift register, so rising and falling edges are held back equally and pulse shapes survive. This suits address lines and cycle-type controls. In the lead-edge mode only the assertion is held back. The output rises once the input has stayed high for the full delay, and it falls in the same cycle the input falls. This suits handshake strobes such as the master and slave syncs. An enable input lets a direction controller turn each instance off. While the enable is low the outputs are low, and any transition in flight is discarded.

Top module: `deskew_line`

## Requirements
- R1: The delay in cycles is the ceiling of `DELAY_NS / CLK_PERIOD_NS`, with a minimum of 1. For example, 75 ns at a 10 ns clock gives 8 cycles and 160 ns gives 16.
- R2: In symmetric mode (`MODE = DSK_BOTH_EDGE`), while `en` stays high, `dout` equals the `din` value sampled that many rising edges earlier. Rising and falling edges are delayed alike.
- R3: In symmetric mode a pulse shorter than the delay, down to a single cycle, appears at the output with its width unchanged.
- R4: In lead-edge mode (`MODE = DSK_RISE_ONLY`), a bit of `dout` goes high after its `din` bit has been sampled high with `en` high on as many consecutive rising edges as the delay.
- R5: In lead-edge mode a bit of `dout` goes low in the same cycle its `din` bit goes low, without waiting for a clock edge.
- R6: In lead-edge mode, if the input bit drops before the delay has expired, the pending assertion is cancelled, no output pulse appears, and the next assertion starts a fresh count.
- R7: While `en` is low every bit of `dout` is low, in the same cycle `en` falls.
- R8: A clock edge with `en` low discards all state in flight. After `en` returns, nothing sampled before the gap reaches `dout`.
- R9: Reset is synchronous and active low. After a reset edge `dout` is all zero, and transitions sampled before reset are lost.
- R10: The bits of a vector instance are delayed independently of one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Direction enable; low forces outputs low and flushes state |
| din | input | WIDTH | Active-high lines entering the repeater |
| dout | output | WIDTH | Deskewed copies of `din` |

## Verification
A two-bit lead-edge instance with a 16-cycle delay and an eight-bit symmetric instance with an 8-cycle delay are both compared with a behavioural model on every cycle. The lead-edge instance gets four patterns. A long assertion shows the exact rise cycle. A high run one cycle short of the delay separates cancellation from a late rise. An immediate drop shows that negation is not clocked. Staggered bits show that their counts are independent. The symmetric instance gets a one-cycle pulse and a wide block, which separate a true shift from edge stretching. Pseudo-random vectors test bit independence. Enable gaps and a mid-stream reset, applied to both instances, show that state in flight is flushed rather than held.

// File: rtl/deskew_pkg.sv
// Shared definitions for the deskew delay unit.
// Assumes: nothing beyond IEEE 1800-2017.
package deskew_pkg;

    // Selects which edges of a line are held back.
    typedef enum logic {
        DSK_BOTH_EDGE = 1'b0,
        DSK_RISE_ONLY = 1'b1
    } dsk_mode_e;

    // Whole-cycle delay from a nanosecond figure, rounded up, never below one.
    function automatic int unsigned dsk_cycles(input int unsigned ns, input int unsigned period_ns);
        int unsigned c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/dsk_rise_cell.sv
// One-bit lead-edge delay: the output rises after the input has been high
// for DELAY_CYC consecutive sampled edges and falls as soon as the input falls.
// Assumes: DELAY_CYC >= 1; en low or din low cancels any pending rise.
module dsk_rise_cell #(
    parameter int unsigned DELAY_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic dout
);
    localparam int unsigned CW = $clog2(DELAY_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

    logic [CW-1:0] cnt;
    logic          armed;

    // Count consecutive high samples; arm once the delay has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (!en || !din) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (!armed) begin
            if (cnt == LAST) armed <= 1'b1;
            else             cnt   <= cnt + 1'b1;
        end
    end

    // Negation is combinational so the falling edge passes without delay.
    assign dout = en & din & armed;

    AST_DROP_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || !din) |=> (!armed && cnt == '0)); // R6
    AST_ARM_AFTER_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(en && din && cnt == LAST)); // R4
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R1

endmodule

// File: rtl/dsk_pipe.sv
// Symmetric delay: a WIDTH-wide shift register DEPTH stages long.
// Assumes: DEPTH >= 1; en low on an edge empties every stage.
module dsk_pipe #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] tail
);
    logic [WIDTH-1:0] stg [DEPTH];

    // Shift the input one stage per cycle, or flush on reset or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            for (int i = 0; i < int'(DEPTH); i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < int'(DEPTH); i++) stg[i] <= stg[i-1];
        end
    end

    assign tail = stg[DEPTH-1];

    AST_FLUSH_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tail == '0 && stg[0] == '0)); // R8
    AST_ENTRY_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> stg[0] == $past(din)); // R2

endmodule

// File: rtl/deskew_line.sv
// Top of the deskew delay unit: converts the nanosecond delay to cycles,
// picks the symmetric or lead-edge variant, and gates the result with en.
// Assumes: CLK_PERIOD_NS >= 1; rst_n is synchronous to clk.
module deskew_line
    import deskew_pkg::*;
#(
    parameter int unsigned WIDTH         = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned DELAY_NS      = 75,
    parameter dsk_mode_e   MODE          = DSK_BOTH_EDGE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int unsigned DELAY_CYC = dsk_cycles(DELAY_NS, CLK_PERIOD_NS);

    logic [WIDTH-1:0] raw;

    // Variant selection: one counter cell per bit, or one shared shift register.
    generate
        if (MODE == DSK_RISE_ONLY) begin : g_rise
            for (genvar b = 0; b < int'(WIDTH); b++) begin : g_bit
                dsk_rise_cell #(.DELAY_CYC(DELAY_CYC)) u_cell (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .en   (en),
                    .din  (din[b]),
                    .dout (raw[b])
                );
            end
        end else begin : g_both
            dsk_pipe #(.WIDTH(WIDTH), .DEPTH(DELAY_CYC)) u_pipe (
                .clk  (clk),
                .rst_n(rst_n),
                .en   (en),
                .din  (din),
                .tail (raw)
            );
        end
    endgenerate

    // Output gate for the direction controller.
    assign dout = en ? raw : '0;

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> dout == '0); // R9

endmodule

// File: tb/sim_deskew_line.sv
// Bench: lead-edge two-bit instance (u0, 16 cycles) and symmetric eight-bit
// instance (u1, 8 cycles), both compared each cycle with a behavioural model.
module sim_deskew_line;
    import deskew_pkg::*;

    localparam int CLK_NS = 10;
    localparam int DR = 16;   // ceil(160/10)
    localparam int DP = 8;    // ceil(75/10)

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_r = 1'b0, en_p = 1'b0;
    logic [1:0] din_r = '0, dout_r;
    logic [7:0] din_p = '0, dout_p;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    string tag_r = "R9", tag_p = "R9";
    int run [2] = '{0, 0};
    logic [7:0] pq [$];
    logic [7:0] lf = 8'hA5;

    always #(CLK_NS/2) clk = ~clk;

    deskew_line #(.WIDTH(2), .CLK_PERIOD_NS(10), .DELAY_NS(160), .MODE(DSK_RISE_ONLY)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en_r), .din(din_r), .dout(dout_r));
    deskew_line #(.WIDTH(8), .CLK_PERIOD_NS(10), .DELAY_NS(75), .MODE(DSK_BOTH_EDGE)) u1 (
        .clk(clk), .rst_n(rst_n), .en(en_p), .din(din_p), .dout(dout_p));

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s cycle %0d: got %h expected %h", tag, what, cyc, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare, then advance the model at posedge.
    task automatic step(input logic r, input logic [1:0] dr, input logic er,
                        input logic [7:0] dp, input logic ep);
        logic [1:0] exp_r;
        logic [7:0] exp_p;
        @(negedge clk);
        rst_n = r; din_r = dr; en_r = er; din_p = dp; en_p = ep;
        #1;
        for (int b = 0; b < 2; b++) exp_r[b] = er & dr[b] & (run[b] >= DR);
        exp_p = ep ? pq[0] : 8'h00;
        if (cyc > 0) begin
            check(tag_r, "lead-edge", {6'b0, dout_r}, {6'b0, exp_r});
            check(tag_p, "symmetric", dout_p, exp_p);
        end
        @(posedge clk);
        for (int b = 0; b < 2; b++) begin
            if (!r || !er || !dr[b]) run[b] = 0;
            else if (run[b] < DR)    run[b] = run[b] + 1;
        end
        if (!r || !ep) begin
            foreach (pq[i]) pq[i] = 8'h00;
        end else begin
            void'(pq.pop_front());
            pq.push_back(dp);
        end
        cyc++;
    endtask

    function automatic logic [7:0] lfsr_next(input logic [7:0] v);
        return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    initial begin : watchdog
        #(CLK_NS * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DP; i++) pq.push_back(8'h00);

        // R9: held in reset with inputs active, outputs stay low.
        tag_r = "R9"; tag_p = "R9";
        repeat (4) step(0, 2'b11, 1, 8'hFF, 1);

        // R4 / R1: 16-cycle rise; R3: one-cycle pulses keep their width.
        tag_r = "R4"; tag_p = "R3";
        for (int i = 0; i < 20; i++)
            step(1, 2'b01, 1, (i == 0) ? 8'h01 : ((i == 3) ? 8'h80 : 8'h00), 1);

        // R5: immediate fall; R1: pipe drains over 8 cycles.
        tag_r = "R5"; tag_p = "R1";
        for (int i = 0; i < 10; i++) step(1, 2'b00, 1, 8'h00, 1);

        // R6: runs of 10 and 15 cycles never assert; R2: wide block shifts intact.
        tag_r = "R6"; tag_p = "R2";
        for (int i = 0; i < 20; i++)
            step(1, {(i < 15), (i < 10)}, 1, (i < 5) ? 8'h3C : 8'h00, 1);

        // R10: staggered bits and pseudo-random vectors.
        tag_r = "R10"; tag_p = "R10";
        for (int i = 0; i < 32; i++) begin
            lf = lfsr_next(lf);
            step(1, {(i >= 8), 1'b1}, 1, lf, 1);
        end

        // R7 then R8: enable gaps while inputs keep moving.
        for (int i = 0; i < 30; i++) begin
            lf = lfsr_next(lf);
            tag_r = (i == 10 || i == 11) ? "R7" : "R8";
            tag_p = tag_r;
            step(1, 2'b11, !(i == 10 || i == 11), lf, !(i == 10 || i == 11));
        end

        // R9: reset in mid-stream discards state.
        tag_r = "R9"; tag_p = "R9";
        for (int i = 0; i < 26; i++) begin
            lf = lfsr_next(lf);
            step(!(i == 4 || i == 5), 2'b11, 1, lf, 1);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule